// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block watches the control pins of a DDR SDRAM command bus and turns each rising-edge sample into a decoded command. The inputs are the clock-enable level from the previous and the current cycle, chip select, the row strobe, the column strobe, write enable, the bank bits and the address bus. One cycle after the sampling edge, the block presents the result. It gives a one-hot command type, the selected bank, the auto-precharge and all-banks flags, and the mode register opcode. It also keeps a per-bank open/closed map. A monitor or a memory model next to a controller would use it to follow what the bus is doing and to catch commands that break the protocol.

A small sequencer keeps the timing context. Its states are READY, MRD_HOLD and SELF_REF. READY moves to MRD_HOLD on a legal mode-register write. It moves to SELF_REF on a legal self-refresh entry. MRD_HOLD counts down the mode-register spacing and returns to READY when the count reaches its last cycle. SELF_REF returns to READY on the cycle where clock enable rises, that is, previous low and current high.

A command that breaks a rule is still reported on the command output, but the illegal flag is raised with it. An illegal command changes neither the bank map nor the sequencer state.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: `cmd_oh` is one-hot, registered one cycle after the sampling edge. The bit positions are: 0 no-op, 1 mode set, 2 extended mode set, 3 activate, 4 read, 5 write, 6 precharge one bank, 7 precharge all, 8 burst stop, 9 refresh, 10 self-refresh entry. The block reports no-op when chip select is high, or when the row strobe, column strobe and write enable are all high. Out of reset, `cmd_oh` is 1 and every other output is 0.
- R2: The decoded command follows the levels of the row strobe, column strobe and write enable, written here as ras/cas/we with 0 meaning low. 011 is activate, 101 is read, 100 is write, 110 is burst stop and 001 is refresh. These apply when clock enable is high on both cycles.
- R3: Pattern 000 is a mode write. Bank bit 0 low selects mode set and bank bit 0 high selects extended mode set. `mode_op` carries the address bus for these two commands and is 0 otherwise.
- R4: Pattern 010 is precharge. With address bit 10 high, it is precharge-all: `all_banks` is 1, `cmd_bank` reads 0 whatever the bank bits say, and every bank closes. With bit 10 low, it closes only the bank given by the bank bits.
- R5: For a read or write, `auto_pre` equals address bit 10. A legal read or write with `auto_pre` set closes its bank.
- R6: The bank bits select bank 0 to 3, with bit 0 as the low bit. `cmd_bank` reports that bank for activate, read, write and single-bank precharge. Bit n of `bank_open` is bank n, and a legal activate sets it.
- R7: `illegal` is raised for a read or write to a closed bank and for an activate to an open bank.
- R8: `illegal` is raised for a mode write, refresh or self-refresh entry while any bank is open.
- R9: After a legal mode write, any command other than no-op in the next MRD_CYCLES-1 cycles is illegal. A no-op there is legal.
- R10: With previous clock enable low, or with a falling clock enable on any pattern other than refresh, the block reports no-op. A falling clock enable with the refresh pattern is self-refresh entry and sets `self_ref`. `self_ref` clears after the cycle where clock enable rises, and commands decode as no-op while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock enable level of the previous cycle |
| cke_cur | input | 1 | Clock enable level of the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank bits |
| addr | input | ADDR_BITS | Address bus (bit AP_BIT is the precharge qualifier) |
| cmd_oh | output | NUM_CMD | One-hot command type |
| cmd_bank | output | BANK_BITS | Selected bank |
| auto_pre | output | 1 | Read/write with auto-precharge |
| all_banks | output | 1 | Precharge applies to every bank |
| mode_op | output | ADDR_BITS | Mode register opcode |
| bank_open | output | 2**BANK_BITS | Per-bank open map |
| illegal | output | 1 | Command breaks a protocol rule |
| self_ref | output | 1 | Sequencer is in self-refresh |

## Verification
The strobe patterns are applied with chip select high and with chip select low. This separates real decoding from commands that are masked out. Each command is then issued with the bank map empty, partly filled and with the target bank in the opposite state, which shows that legality is checked per bank and not globally. Address bit 10 is toggled on read, write and precharge, with mismatched bank bits, to show that the qualifier changes both the command and which banks close. Clock-enable sequences of low-high, high-low and low-low keep self-refresh entry apart from plain masked cycles. The mode-write spacing is probed with a no-op and with an activate in the gap cycle.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_EMRS = 4'd2,
        CMD_ACT  = 4'd3,
        CMD_RD   = 4'd4,
        CMD_WR   = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_PREA = 4'd7,
        CMD_BST  = 4'd8,
        CMD_REF  = 4'd9,
        CMD_SREF = 4'd10
    } cmd_e;

    localparam int NUM_CMD = 11;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_MRD_HOLD = 2'd1,
        ST_SELF_REF = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ddr_cmd_field_decode.sv
module ddr_cmd_field_decode
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ADDR_BITS = 13,
    parameter int AP_BIT    = 10
) (
    input  logic                 cke_prev,
    input  logic                 cke_cur,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_BITS-1:0] ba,
    input  logic [ADDR_BITS-1:0] addr,
    output cmd_e                 cmd,
    output logic                 ap_flag
);

    logic [2:0] strobes;
    assign strobes = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = CMD_NOP;
        if (!cke_prev || cs_n) begin
            cmd = CMD_NOP;
        end else if (!cke_cur) begin
            // falling clock enable only means something with refresh
            cmd = (strobes == 3'b001) ? CMD_SREF : CMD_NOP;
        end else begin
            unique case (strobes)
                3'b000:  cmd = ba[0] ? CMD_EMRS : CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = addr[AP_BIT] ? CMD_PREA : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WR;
                3'b101:  cmd = CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    assign ap_flag = addr[AP_BIT] && ((cmd == CMD_RD) || (cmd == CMD_WR));

endmodule

// File: rtl/ddr_cmd_seq_fsm.sv
module ddr_cmd_seq_fsm
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_BITS  = 2,
    parameter int MRD_CYCLES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_prev,
    input  logic                    cke_cur,
    input  cmd_e                    cmd_raw,
    input  logic [BANK_BITS-1:0]    bank,
    input  logic [(1<<BANK_BITS)-1:0] bank_open,
    output cmd_e                    cmd_eff,
    output logic                    illegal,
    output logic                    self_ref
);

    localparam int CNT_W = $clog2(MRD_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(MRD_CYCLES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic any_open;
    logic tgt_open;
    logic needs_idle;

    assign any_open = |bank_open;
    assign tgt_open = bank_open[bank];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs: effective command and legality
    always_comb begin
        cmd_eff = (state_q == ST_SELF_REF) ? CMD_NOP : cmd_raw;
        needs_idle = (cmd_eff == CMD_MRS) || (cmd_eff == CMD_EMRS) ||
                     (cmd_eff == CMD_REF) || (cmd_eff == CMD_SREF);
        illegal = 1'b0;
        if ((state_q == ST_MRD_HOLD) && (cmd_eff != CMD_NOP))
            illegal = 1'b1;
        if ((cmd_eff == CMD_ACT) && tgt_open)
            illegal = 1'b1;
        if (((cmd_eff == CMD_RD) || (cmd_eff == CMD_WR)) && !tgt_open)
            illegal = 1'b1;
        if (needs_idle && any_open)
            illegal = 1'b1;
        self_ref = (state_q == ST_SELF_REF);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_READY: begin
                if (!illegal && ((cmd_eff == CMD_MRS) || (cmd_eff == CMD_EMRS))) begin
                    state_d = ST_MRD_HOLD;
                    cnt_d   = HOLD_LOAD;
                end else if (!illegal && (cmd_eff == CMD_SREF)) begin
                    state_d = ST_SELF_REF;
                end
            end
            ST_MRD_HOLD: begin
                if (cnt_q <= HOLD_LAST) begin
                    state_d = ST_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_SELF_REF: begin
                if (!cke_prev && cke_cur)
                    state_d = ST_READY;
            end
            default: begin
                state_d = ST_READY;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  cmd_e                      cmd,
    input  logic                      legal,
    input  logic                      ap_flag,
    input  logic [BANK_BITS-1:0]      bank,
    output logic [(1<<BANK_BITS)-1:0] bank_open
);

    localparam int NUM_BANKS = 1 << BANK_BITS;

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic hit;
        logic do_open;
        logic do_close;

        assign hit      = (bank == BANK_BITS'(gi));
        assign do_open  = legal && hit && (cmd == CMD_ACT);
        assign do_close = legal && ((cmd == CMD_PREA) ||
                                    (hit && (cmd == CMD_PRE)) ||
                                    (hit && ap_flag &&
                                     ((cmd == CMD_RD) || (cmd == CMD_WR))));

        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_open[gi] <= 1'b0;
            else if (do_open)
                bank_open[gi] <= 1'b1;
            else if (do_close)
                bank_open[gi] <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_BITS  = 2,
    parameter int ADDR_BITS  = 13,
    parameter int AP_BIT     = 10,
    parameter int MRD_CYCLES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke_prev,
    input  logic                      cke_cur,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BANK_BITS-1:0]      ba,
    input  logic [ADDR_BITS-1:0]      addr,
    output logic [NUM_CMD-1:0]        cmd_oh,
    output logic [BANK_BITS-1:0]      cmd_bank,
    output logic                      auto_pre,
    output logic                      all_banks,
    output logic [ADDR_BITS-1:0]      mode_op,
    output logic [(1<<BANK_BITS)-1:0] bank_open,
    output logic                      illegal,
    output logic                      self_ref
);

    cmd_e cmd_raw;
    cmd_e cmd_eff;
    logic ap_raw;
    logic ill_now;
    logic banked;

    ddr_cmd_field_decode #(
        .BANK_BITS(BANK_BITS),
        .ADDR_BITS(ADDR_BITS),
        .AP_BIT   (AP_BIT)
    ) u_decode (
        .cke_prev(cke_prev),
        .cke_cur (cke_cur),
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ba      (ba),
        .addr    (addr),
        .cmd     (cmd_raw),
        .ap_flag (ap_raw)
    );

    ddr_cmd_seq_fsm #(
        .BANK_BITS (BANK_BITS),
        .MRD_CYCLES(MRD_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_prev (cke_prev),
        .cke_cur  (cke_cur),
        .cmd_raw  (cmd_raw),
        .bank     (ba),
        .bank_open(bank_open),
        .cmd_eff  (cmd_eff),
        .illegal  (ill_now),
        .self_ref (self_ref)
    );

    ddr_bank_tracker #(
        .BANK_BITS(BANK_BITS)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd_eff),
        .legal    (!ill_now),
        .ap_flag  (ap_raw),
        .bank     (ba),
        .bank_open(bank_open)
    );

    assign banked = (cmd_eff == CMD_ACT) || (cmd_eff == CMD_RD) ||
                    (cmd_eff == CMD_WR)  || (cmd_eff == CMD_PRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_oh    <= NUM_CMD'(1);
            cmd_bank  <= '0;
            auto_pre  <= 1'b0;
            all_banks <= 1'b0;
            mode_op   <= '0;
            illegal   <= 1'b0;
        end else begin
            cmd_oh    <= NUM_CMD'(1) << cmd_eff;
            cmd_bank  <= banked ? ba : '0;
            auto_pre  <= ap_raw && (cmd_eff != CMD_NOP);
            all_banks <= (cmd_eff == CMD_PREA);
            mode_op   <= ((cmd_eff == CMD_MRS) || (cmd_eff == CMD_EMRS)) ? addr : '0;
            illegal   <= ill_now;
        end
    end

endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk
    import ddr_cmd_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CMD-1:0]        cmd_oh,
    input logic [BANK_BITS-1:0]      cmd_bank,
    input logic                      auto_pre,
    input logic                      all_banks,
    input logic [(1<<BANK_BITS)-1:0] bank_open,
    input logic                      illegal,
    input logic                      self_ref
);

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_oh) == 1); // R1

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oh[CMD_ACT] && !illegal) |-> bank_open[cmd_bank]); // R6

    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oh[CMD_PREA] && !illegal) |-> (bank_open == '0)); // R4

    AST_ALLB_ONLY_PREA: assert property (@(posedge clk) disable iff (!rst_n)
        all_banks |-> cmd_oh[CMD_PREA]); // R4

    AST_AP_ONLY_RW: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd_oh[CMD_RD] || cmd_oh[CMD_WR])); // R5

    AST_MODE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_oh[CMD_MRS] || cmd_oh[CMD_EMRS] || cmd_oh[CMD_REF] ||
          cmd_oh[CMD_SREF]) && !illegal) |-> ($past(bank_open) == '0)); // R8

    AST_MRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_oh[CMD_MRS] || cmd_oh[CMD_EMRS]) && !illegal) |=>
        (cmd_oh[CMD_NOP] || illegal)); // R9

    AST_SREF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_oh[CMD_SREF] && !illegal) |-> self_ref); // R10

    AST_SREF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(self_ref) && self_ref) |-> cmd_oh[CMD_NOP]); // R10

endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(.BANK_BITS(BANK_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_oh   (cmd_oh),
    .cmd_bank (cmd_bank),
    .auto_pre (auto_pre),
    .all_banks(all_banks),
    .bank_open(bank_open),
    .illegal  (illegal),
    .self_ref (self_ref)
);

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;

    localparam int K_NOP = 0, K_MRS = 1, K_EMRS = 2, K_ACT = 3, K_RD = 4, K_WR = 5,
                   K_PRE = 6, K_PREA = 7, K_BST = 8, K_REF = 9, K_SREF = 10;
    localparam logic [12:0] A10 = 13'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_prev = 1'b1, cke_cur = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [10:0] cmd_oh;
    logic [1:0]  cmd_bank;
    logic        auto_pre, all_banks, illegal, self_ref;
    logic [12:0] mode_op;
    logic [3:0]  bank_open;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_cur(cke_cur),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_oh(cmd_oh), .cmd_bank(cmd_bank), .auto_pre(auto_pre), .all_banks(all_banks),
        .mode_op(mode_op), .bank_open(bank_open), .illegal(illegal), .self_ref(self_ref)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_cmd(input string tag, input int k, input logic exp_ill);
        chk({tag, " cmd"}, 16'(cmd_oh), 16'(11'(1) << k));
        chk({tag, " illegal"}, 16'(illegal), 16'(exp_ill));
    endtask

    // drive at negedge, outputs are visible at the following negedge
    task automatic send(input logic cp, input logic cc, input logic cs, input logic r,
                        input logic c, input logic w, input logic [1:0] b,
                        input logic [12:0] a);
        cke_prev = cp; cke_cur = cc; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = b; addr = a;
        @(negedge clk);
    endtask

    task automatic op(input logic r, input logic c, input logic w,
                      input logic [1:0] b, input logic [12:0] a);
        send(1'b1, 1'b1, 1'b0, r, c, w, b, a);
    endtask

    task automatic t_reset;
        chk("R1 reset cmd", 16'(cmd_oh), 16'h0001);
        chk("R1 reset open", 16'(bank_open), 16'h0);
        chk("R1 reset illegal", 16'(illegal), 16'h0);
        chk("R1 reset self_ref", 16'(self_ref), 16'h0);
    endtask

    task automatic t_nop;
        send(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R1 cs high", K_NOP, 1'b0);
        chk("R1 cs high open", 16'(bank_open), 16'h0);
        op(1'b1, 1'b1, 1'b1, 2'd3, 13'h1FFF);
        chk_cmd("R1 strobes high", K_NOP, 1'b0);
    endtask

    task automatic t_plain;
        op(1'b0, 1'b0, 1'b1, 2'd0, 13'h0);
        chk_cmd("R2 refresh", K_REF, 1'b0);
        op(1'b1, 1'b1, 1'b0, 2'd0, 13'h0);
        chk_cmd("R2 burst stop", K_BST, 1'b0);
    endtask

    task automatic t_mode;
        op(1'b0, 1'b0, 1'b0, 2'd0, 13'h0123);
        chk_cmd("R3 mode set", K_MRS, 1'b0);
        chk("R3 opcode", 16'(mode_op), 16'h0123);
        op(1'b0, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R9 act in gap", K_ACT, 1'b1);
        chk("R9 gap open", 16'(bank_open), 16'h0);
        chk("R3 opcode cleared", 16'(mode_op), 16'h0);
        op(1'b0, 1'b0, 1'b0, 2'd1, 13'h0045);
        chk_cmd("R3 ext mode set", K_EMRS, 1'b0);
        chk("R3 ext opcode", 16'(mode_op), 16'h0045);
        op(1'b1, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R9 nop in gap", K_NOP, 1'b0);
        op(1'b0, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R9 act after gap", K_ACT, 1'b0);
        chk("R6 open bank0", 16'(bank_open), 16'h1);
    endtask

    task automatic t_bank;
        op(1'b0, 1'b1, 1'b1, 2'd2, 13'h0);
        chk_cmd("R6 act bank2", K_ACT, 1'b0);
        chk("R6 bank2 sel", 16'(cmd_bank), 16'd2);
        chk("R6 open 0101", 16'(bank_open), 16'h5);
        op(1'b0, 1'b1, 1'b1, 2'd2, 13'h0);
        chk_cmd("R7 act open bank", K_ACT, 1'b1);
        chk("R7 map kept", 16'(bank_open), 16'h5);
        op(1'b1, 1'b0, 1'b1, 2'd1, 13'h0);
        chk_cmd("R7 read closed", K_RD, 1'b1);
        op(1'b1, 1'b0, 1'b1, 2'd2, 13'h0);
        chk_cmd("R2 read", K_RD, 1'b0);
        chk("R5 read no ap", 16'(auto_pre), 16'h0);
        chk("R5 read keeps open", 16'(bank_open), 16'h5);
        op(1'b1, 1'b0, 1'b0, 2'd2, A10);
        chk_cmd("R2 write", K_WR, 1'b0);
        chk("R5 write ap", 16'(auto_pre), 16'h1);
        chk("R5 ap closes", 16'(bank_open), 16'h1);
        op(1'b0, 1'b0, 1'b0, 2'd0, 13'h0011);
        chk_cmd("R8 mode with open", K_MRS, 1'b1);
        op(1'b0, 1'b0, 1'b1, 2'd0, 13'h0);
        chk_cmd("R8 refresh with open", K_REF, 1'b1);
        chk("R8 map kept", 16'(bank_open), 16'h1);
    endtask

    task automatic t_pre;
        op(1'b0, 1'b1, 1'b1, 2'd1, 13'h0);
        op(1'b0, 1'b1, 1'b1, 2'd3, 13'h0);
        chk("R6 open 1011", 16'(bank_open), 16'hB);
        op(1'b0, 1'b1, 1'b0, 2'd1, 13'h0);
        chk_cmd("R4 precharge one", K_PRE, 1'b0);
        chk("R4 one bank sel", 16'(cmd_bank), 16'd1);
        chk("R4 not all", 16'(all_banks), 16'h0);
        chk("R4 open 1001", 16'(bank_open), 16'h9);
        op(1'b0, 1'b1, 1'b0, 2'd2, A10);
        chk_cmd("R4 precharge all", K_PREA, 1'b0);
        chk("R4 all flag", 16'(all_banks), 16'h1);
        chk("R4 bank ignored", 16'(cmd_bank), 16'd0);
        chk("R4 all closed", 16'(bank_open), 16'h0);
    endtask

    task automatic t_cke;
        send(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R10 prev low", K_NOP, 1'b0);
        chk("R10 prev low open", 16'(bank_open), 16'h0);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 13'h0);
        chk_cmd("R10 falling act", K_NOP, 1'b0);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 13'h0);
        chk_cmd("R10 self refresh", K_SREF, 1'b0);
        chk("R10 in self ref", 16'(self_ref), 16'h1);
        send(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 13'h0);
        chk_cmd("R10 quiet", K_NOP, 1'b0);
        chk("R10 still self ref", 16'(self_ref), 16'h1);
        send(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0);
        chk("R10 exit", 16'(self_ref), 16'h0);
        op(1'b0, 1'b1, 1'b1, 2'd3, 13'h0);
        chk_cmd("R10 act after exit", K_ACT, 1'b0);
        chk("R6 open bank3", 16'(bank_open), 16'h8);
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 13'h0);
        chk_cmd("R8 sref with open", K_SREF, 1'b1);
        chk("R8 no self ref", 16'(self_ref), 16'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nop();
        t_plain();
        t_mode();
        t_bank();
        t_pre();
        t_cke();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule